// File: doc/BRIEF.md
# Double-Buffered PWM Compare Bank

This block keeps seven compare values for a PWM timer, numbered 0 to 6. Each value has two copies: a staging copy that software writes and a live copy that the comparators use. Software writes go through a plain single-cycle write strobe and change only the staging copies. A separate arm register holds one bit per compare value. It decides which staging copies move into the live copies at the next period boundary.

The period boundary is the cycle in which the internal period counter equals live compare 0. In that cycle the counter returns to zero on the next clock. Every armed staging copy is copied into its live register in that cycle, and the whole arm register then clears. Because of this, several compare values can be changed together and reach the output in the same period. One channel drives a dual-edge output: it is raised by compare 1 and lowered by compare 2. This shows that a timing change made through the bank has no glitch.

The live compare values, the counter and the boundary strobe are level signals for a downstream edge generator. They carry no valid/ready handshake, because a consumer cannot apply back-pressure to a timer. A read port returns live values, and a debug port shows the staging copies.

Top module: `pwm_match_bank`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` in 0..6 changes only the staging copy at that index. A read of addresses 0..6 returns the live value, which the write leaves unchanged.
- R2: Address 7 is the arm register. Bit k (k = 0..6) arms compare k. Write data bit 7 is ignored, and a read of address 7 returns bit 7 and all higher bits as zero.
- R3: In a boundary cycle, each armed compare takes its staging value into its live register at the clock edge ending that cycle. Unarmed compares keep their live value.
- R4: After the edge ending a boundary cycle, the arm register reads zero, unless a write to it arrived in that same cycle.
- R5: A staging value has no effect on the live value or the outputs while it is unarmed. It also has no effect while it is armed and no boundary cycle has yet occurred.
- R6: Compares armed by a single arm write change together in one period, whatever order their staging writes came in.
- R7: After reset the period counter, all live and staging values, the arm register and `pwm_dual` are zero.
- R8: While `run` is high, the counter rises by one each clock. `match0_evt` is high when `run` is high and the counter equals live compare 0, and the counter is zero after that edge, so a period lasts live compare 0 plus one clocks. While `run` is low the counter holds.
- R9: `pwm_dual` is registered. It goes to 1 after a cycle in which the counter equals live compare 1, and to 0 after a cycle in which the counter equals live compare 2. Clearing wins when both match in the same cycle.
- R10: An arm write in a boundary cycle does not act in that cycle. Its bits stay set and take effect at the following boundary.
- R11: A staging write in a boundary cycle lets the previous staging value reach the live register. The new value stays staged.
- R12: `dbg_shadow` shows the staging copy selected by `dbg_sel`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter enable (PWM mode) |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Write address: 0..6 compare, 7 arm register |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Live compare value or arm register |
| dbg_sel | input | 3 | Staging copy selector |
| dbg_shadow | output | 16 | Selected staging copy |
| count | output | 16 | Period counter |
| match0_evt | output | 1 | Period boundary strobe |
| act_match | output | 112 | Live compares, index k at bits 16k+15..16k |
| pwm_dual | output | 1 | Dual-edge output set by compare 1, cleared by compare 2 |

## Verification
Two functions can fall in the same cycle: a bus write and the boundary commit. The bench waits at a falling edge until the counter is one below live compare 0. It then strobes a write in the next cycle, which is the boundary cycle. It does this once with an arm write and once with a staging write. A scoreboard of expected read values then checks two things: that the arm bits survived and committed one period later, and that the live register took the older staging value while the newer one stayed staged.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;
  localparam int unsigned DEF_CNT_W     = 16;
  localparam int unsigned DEF_NUM_MATCH = 7;
  localparam int unsigned DEF_SET_IDX   = 1;
  localparam int unsigned DEF_CLR_IDX   = 2;

  function automatic int unsigned addr_bits(input int unsigned n_match);
    return $clog2(n_match + 1);
  endfunction
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap  = run && (cnt_q == limit);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_arm_ctrl.sv
module pwm_arm_ctrl #(
  parameter int unsigned NUM_MATCH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_wr,
  input  logic [NUM_MATCH-1:0] arm_data,
  input  logic                 boundary,
  output logic [NUM_MATCH-1:0] arm,
  output logic [NUM_MATCH-1:0] commit
);
  logic [NUM_MATCH-1:0] arm_q;

  assign arm    = arm_q;
  assign commit = boundary ? arm_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)        arm_q <= '0;
    else if (arm_wr)   arm_q <= arm_data;
    else if (boundary) arm_q <= '0;
  end

  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !arm_wr) |=> (arm_q == '0));
  a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && arm_wr) |=> (arm_q == $past(arm_data)));
  a_r5_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !arm_wr) |=> $stable(arm_q));
endmodule

// File: rtl/pwm_compare_slot.sv
module pwm_compare_slot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stage_wr,
  input  logic [CNT_W-1:0] stage_data,
  input  logic             take,
  output logic [CNT_W-1:0] staged,
  output logic [CNT_W-1:0] live
);
  logic [CNT_W-1:0] stage_q, live_q;

  assign staged = stage_q;
  assign live   = live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (stage_wr) stage_q <= stage_data;
      if (take)     live_q  <= stage_q;
    end
  end

  a_r1_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(live_q));
  a_r3_take_stage: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (live_q == $past(stage_q)));
  a_r11_stage_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stage_wr |=> (stage_q == $past(stage_data)));
endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] rise_at,
  input  logic [CNT_W-1:0] fall_at,
  output logic             pwm
);
  logic pwm_q;
  logic hit_rise, hit_fall;

  assign hit_rise = run && (count == rise_at);
  assign hit_fall = run && (count == fall_at);
  assign pwm      = pwm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pwm_q <= 1'b0;
    else if (hit_fall) pwm_q <= 1'b0;
    else if (hit_rise) pwm_q <= 1'b1;
  end

  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == rise_at && count != fall_at) |=> pwm_q);
  a_r9_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == fall_at) |=> !pwm_q);
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
  import pwm_match_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned NUM_MATCH = DEF_NUM_MATCH,
  parameter int unsigned SET_IDX   = DEF_SET_IDX,
  parameter int unsigned CLR_IDX   = DEF_CLR_IDX,
  localparam int unsigned ADDR_W   = addr_bits(NUM_MATCH),
  localparam int unsigned ARM_ADDR = NUM_MATCH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CNT_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [CNT_W-1:0]           rd_data,
  input  logic [ADDR_W-1:0]          dbg_sel,
  output logic [CNT_W-1:0]           dbg_shadow,
  output logic [CNT_W-1:0]           count,
  output logic                       match0_evt,
  output logic [NUM_MATCH*CNT_W-1:0] act_match,
  output logic                       pwm_dual
);
  logic [CNT_W-1:0]     live   [NUM_MATCH];
  logic [CNT_W-1:0]     staged [NUM_MATCH];
  logic [NUM_MATCH-1:0] arm, commit;
  logic                 arm_wr;

  assign arm_wr = wr_en && (wr_addr == ADDR_W'(ARM_ADDR));

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(live[0]),
    .count(count), .wrap(match0_evt)
  );

  pwm_arm_ctrl #(.NUM_MATCH(NUM_MATCH)) u_arm (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr),
    .arm_data(wr_data[NUM_MATCH-1:0]), .boundary(match0_evt),
    .arm(arm), .commit(commit)
  );

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_slot
    logic slot_wr;
    assign slot_wr = wr_en && (wr_addr == ADDR_W'(g));
    pwm_compare_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .stage_wr(slot_wr), .stage_data(wr_data),
      .take(commit[g]), .staged(staged[g]), .live(live[g])
    );
    assign act_match[g*CNT_W +: CNT_W] = live[g];
  end

  pwm_dual_edge #(.CNT_W(CNT_W)) u_dual (
    .clk(clk), .rst_n(rst_n), .run(run), .count(count),
    .rise_at(live[SET_IDX]), .fall_at(live[CLR_IDX]), .pwm(pwm_dual)
  );

  always_comb begin
    rd_data    = '0;
    dbg_shadow = '0;
    if (rd_addr == ADDR_W'(ARM_ADDR)) rd_data = CNT_W'(arm);
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data    = live[i];
      if (dbg_sel == ADDR_W'(i)) dbg_shadow = staged[i];
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(ARM_ADDR)) |-> (rd_data[CNT_W-1:NUM_MATCH] == '0));
  a_r5_no_take_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !match0_evt |=> $stable(act_match));
endmodule

// File: tb/test_pwm_match_bank.sv
module test_pwm_match_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_shadow;
  logic [15:0] count;
  logic        match0_evt;
  logic [111:0] act_match;
  logic        pwm_dual;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  pwm_match_bank i_pwm_match_bank (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_sel(dbg_sel), .dbg_shadow(dbg_shadow), .count(count),
    .match0_evt(match0_evt), .act_match(act_match), .pwm_dual(pwm_dual)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected read per cycle at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(it.tag, {16'h0, rd_data}, {16'h0, it.exp});
    end
  end

  // all driver tasks start and end just after a rising edge
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic sb_read(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd_item_t it;
    rd_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wait_evt();
    do @(negedge clk); while (!match0_evt);
    @(posedge clk); #1;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    do @(negedge clk); while (count != v);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R7 counter", {16'h0, count}, 0);
    check("R7 pwm", {31'h0, pwm_dual}, 0);
    check("R7 live", act_match[31:0], 0);
    check("R7 staging", {16'h0, dbg_shadow}, 0);
    @(posedge clk); #1;
    sb_read(3'd7, 16'h0000, "R7 arm reg");

    // stage values with counter stopped
    bus_write(3'd0, 16'd9);
    bus_write(3'd1, 16'd2);
    bus_write(3'd2, 16'd6);
    sb_read(3'd0, 16'd0, "R1 live unchanged");
    dbg_sel = 3'd0;
    @(negedge clk);
    check("R12 debug staging", {16'h0, dbg_shadow}, 9);
    @(posedge clk); #1;

    bus_write(3'd7, 16'h0087);
    sb_read(3'd7, 16'h0007, "R2 bit7 ignored");
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R5 armed no boundary", {16'h0, act_match[31:16]}, 0);
    @(posedge clk); #1;

    run = 1'b1;
    wait_evt();
    sb_read(3'd0, 16'd9, "R3 compare0");
    sb_read(3'd1, 16'd2, "R3 compare1");
    sb_read(3'd2, 16'd6, "R3 compare2");
    sb_read(3'd7, 16'd0, "R4 arm cleared");

    // period length
    do @(negedge clk); while (!match0_evt);
    n = 0;
    do begin @(negedge clk); n++; end while (!match0_evt);
    check("R8 period", n, 10);
    check("R8 count at boundary", {16'h0, count}, 9);

    wait_cnt(16'd2); check("R9 low before rise", {31'h0, pwm_dual}, 0);
    wait_cnt(16'd3); check("R9 high after rise", {31'h0, pwm_dual}, 1);
    wait_cnt(16'd7); check("R9 low after fall", {31'h0, pwm_dual}, 0);
    @(posedge clk); #1;

    // unarmed staging write
    bus_write(3'd1, 16'd4);
    wait_evt();
    wait_evt();
    sb_read(3'd1, 16'd2, "R5 unarmed no effect");

    // atomic pair, written in reverse order
    bus_write(3'd2, 16'd8);
    bus_write(3'd1, 16'd5);
    bus_write(3'd7, 16'h0006);
    sb_read(3'd1, 16'd2, "R6 old before boundary");
    wait_evt();
    sb_read(3'd1, 16'd5, "R6 compare1 new");
    sb_read(3'd2, 16'd8, "R6 compare2 new");
    wait_cnt(16'd4); check("R9 new period low", {31'h0, pwm_dual}, 0);
    wait_cnt(16'd7); check("R9 new period high", {31'h0, pwm_dual}, 1);
    wait_cnt(16'd9); check("R9 new period cleared", {31'h0, pwm_dual}, 0);
    @(posedge clk); #1;

    // arm write in the boundary cycle
    bus_write(3'd0, 16'd7);
    wait_cnt(16'd8);
    @(posedge clk); #1;
    bus_write(3'd7, 16'h0001);
    sb_read(3'd0, 16'd9, "R10 not applied at once");
    sb_read(3'd7, 16'h0001, "R10 arm kept");
    wait_evt();
    sb_read(3'd0, 16'd7, "R10 applied next boundary");
    sb_read(3'd7, 16'h0000, "R4 arm cleared again");

    // staging write in the boundary cycle
    bus_write(3'd1, 16'd3);
    bus_write(3'd7, 16'h0002);
    wait_cnt(16'd6);
    @(posedge clk); #1;
    bus_write(3'd1, 16'd1);
    sb_read(3'd1, 16'd3, "R11 old staging committed");
    dbg_sel = 3'd1;
    @(negedge clk);
    check("R11 new value staged", {16'h0, dbg_shadow}, 1);
    check("R11 live port", {16'h0, act_match[31:16]}, 3);
    @(posedge clk); #1;
    sb_read(3'd7, 16'h0000, "R4 arm clear after R11");

    @(posedge clk); #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule